// File: doc/BRIEF.md
# BCD Real-Time Calendar with Two-Stage Prescaler

This block keeps time of day and calendar date in packed BCD. It runs from a slow real-time clock, nominally 32.768 kHz. A down-counting first prescaler stage divides that clock into a sub-second enable. A second down-counting stage divides the enable into a one-second tick. The second stage's current count is presented as a binary sub-second value. Each tick advances seconds, minutes and hours, either in 24-hour form or in 12-hour form with an afternoon flag. A day carry then advances weekday, day of month, month and a two-digit year, with month lengths and leap Februaries handled.

Software sets the clock by raising the initialization input. While that input is high, both prescaler stages sit at their reload values and the calendar holds. Parallel load strobes write a full time word and a full date word. Releasing initialization starts counting from a whole second.

Top module: `rtc_calendar`

## Requirements
- R1: After reset, time_o is 0 (00:00:00, flag clear), date_o is year 00, weekday 1, month 01, day 01, and tick_o is low.
- R2: With initialization low, tick_o pulses for one cycle every (apre_i+1)*(spre_i+1) clock cycles. The first pulse is visible that many cycles after initialization is released.
- R3: subsec_o holds spre_i while initialization is high. It counts down by one every apre_i+1 cycles, wraps from 0 back to spre_i, and the tick is produced at that wrap.
- R4: Time word layout: bits 3:0 seconds units, 6:4 seconds tens, 10:7 minutes units, 13:11 minutes tens, 17:14 hours units, 19:18 hours tens, 20 afternoon flag. With fmt12_i low, each tick advances the time in BCD. 59 seconds carries to minutes, 59 minutes carries to hours, and 23:59:59 goes to 00:00:00 with one day advance.
- R5: With fmt12_i high, hours run 12, 1, ..., 11. The step from 11 to 12 toggles the flag in bit 20 (1 = afternoon), and 12 steps to 1 without touching the flag.
- R6: In 12-hour counting, 11:59:59 with the flag set goes to 12:00:00 with the flag clear and advances the date. The same step from the morning advances no date.
- R7: Date word layout: bits 3:0 day units, 5:4 day tens, 9:6 month units, 10 month tens, 13:11 weekday, 17:14 year units, 21:18 year tens. A day advance after the last day of a month sets the day to 01 and the month +1. Months 4, 6, 9 and 11 end on day 30, February as in R8, all others on day 31.
- R8: February ends on day 29 when the two-digit year is divisible by 4 (00 included) and on day 28 otherwise.
- R9: Each day advance moves the weekday up by one, and weekday 7 goes to 1.
- R10: A day advance from month 12, day 31 gives month 01, day 01 and the next year. Year 99 wraps to 00.
- R11: time_ld_i and date_ld_i load time_i and date_i only while init_i is high. Strobes with init_i low leave the outputs unchanged.
- R12: While init_i is high, the calendar does not advance and no tick is produced. When init_i falls, both prescaler stages start from their reload values, so the next tick comes a full period later whatever their state before.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Real-time counting clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| apre_i | input | 7 | First-stage reload value (divide by value+1) |
| spre_i | input | 15 | Second-stage reload value (divide by value+1) |
| fmt12_i | input | 1 | 1 = 12-hour counting, 0 = 24-hour |
| init_i | input | 1 | Initialization mode: freeze and allow loads |
| time_ld_i | input | 1 | Load strobe for time_i |
| time_i | input | 21 | Time word to load |
| date_ld_i | input | 1 | Load strobe for date_i |
| date_i | input | 22 | Date word to load |
| time_o | output | 21 | Current time word |
| date_o | output | 22 | Current date word |
| subsec_o | output | 15 | Second-stage down count |
| tick_o | output | 1 | One-cycle pulse per second |

## Verification
The hard part is reaching month, year and leap boundaries, which from the ports would take days or years of ticking. The bench gets there in a few cycles. It holds the calendar in initialization, loads a time of 23:59:59 and a date just before the boundary, shrinks both prescalers to a few cycles, releases initialization for a single tick, and compares both words. It also freezes the prescalers mid-count to show that a release restarts the full period.

// File: rtl/rtc_cal_pkg.sv
package rtc_cal_pkg;
  localparam int TIME_W = 21;
  localparam int DATE_W = 22;

  typedef struct packed {
    logic       pm;
    logic [1:0] ht;
    logic [3:0] hu;
    logic [2:0] mnt;
    logic [3:0] mnu;
    logic [2:0] st;
    logic [3:0] su;
  } time_t;

  typedef struct packed {
    logic [3:0] yt;
    logic [3:0] yu;
    logic [2:0] wd;
    logic       mt;
    logic [3:0] mu;
    logic [1:0] dt;
    logic [3:0] du;
  } date_t;

  function automatic logic [6:0] bcd2bin(input logic [7:0] b);
    return 7'(b[7:4] * 7'd10 + 7'(b[3:0]));
  endfunction

  function automatic logic [3:0] tens4(input logic [6:0] v);
    return 4'(v / 7'd10);
  endfunction

  function automatic logic [3:0] units4(input logic [6:0] v);
    return 4'(v % 7'd10);
  endfunction

  // leap rule on binary year: low two bits zero
  function automatic logic [6:0] month_days(input logic [6:0] mo, input logic [6:0] yr);
    case (mo)
      7'd2:                         return (yr[1:0] == 2'b00) ? 7'd29 : 7'd28;
      7'd4, 7'd6, 7'd9, 7'd11:      return 7'd30;
      default:                      return 7'd31;
    endcase
  endfunction
endpackage

// File: rtl/rtc_prescaler.sv
module rtc_prescaler #(
  parameter int APRE_W = 7,
  parameter int SPRE_W = 15
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              run_i,
  input  logic [APRE_W-1:0] apre_i,
  input  logic [SPRE_W-1:0] spre_i,
  output logic [SPRE_W-1:0] subsec_o,
  output logic              sec_tick_o
);
  logic [APRE_W-1:0] acnt_q;
  logic [SPRE_W-1:0] scnt_q;
  logic a_zero, s_zero;

  assign a_zero     = (acnt_q == '0);
  assign s_zero     = (scnt_q == '0);
  assign sec_tick_o = run_i & a_zero & s_zero;
  assign subsec_o   = scnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acnt_q <= '0;
      scnt_q <= '0;
    end else if (!run_i) begin
      acnt_q <= apre_i;
      scnt_q <= spre_i;
    end else begin
      acnt_q <= a_zero ? apre_i : acnt_q - 1'b1;
      if (a_zero) scnt_q <= s_zero ? spre_i : scnt_q - 1'b1;
    end
  end
endmodule

// File: rtl/rtc_time_ctr.sv
module rtc_time_ctr
  import rtc_cal_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              fmt12_i,
  input  logic              tick_i,
  input  logic              ld_i,
  input  logic [TIME_W-1:0] ld_val_i,
  output logic [TIME_W-1:0] time_o,
  output logic              day_inc_o
);
  time_t q, n;
  logic [6:0] s, m, h, s_n, m_n, h_n;
  logic pm_n, roll, hr_step;

  always_comb begin
    s = bcd2bin({1'b0, q.st, q.su});
    m = bcd2bin({1'b0, q.mnt, q.mnu});
    h = bcd2bin({2'b00, q.ht, q.hu});
    hr_step = (s == 7'd59) && (m == 7'd59);
    s_n  = (s == 7'd59) ? 7'd0 : s + 7'd1;
    m_n  = (s == 7'd59) ? ((m == 7'd59) ? 7'd0 : m + 7'd1) : m;
    h_n  = h;
    pm_n = q.pm;
    roll = 1'b0;
    if (hr_step) begin
      if (fmt12_i) begin
        if (h == 7'd11) begin
          h_n  = 7'd12;
          pm_n = ~q.pm;
          roll = q.pm;
        end else if (h == 7'd12) begin
          h_n = 7'd1;
        end else begin
          h_n = h + 7'd1;
        end
      end else if (h == 7'd23) begin
        h_n  = 7'd0;
        roll = 1'b1;
      end else begin
        h_n = h + 7'd1;
      end
    end
    n.pm  = pm_n;
    n.ht  = 2'(tens4(h_n));
    n.hu  = units4(h_n);
    n.mnt = 3'(tens4(m_n));
    n.mnu = units4(m_n);
    n.st  = 3'(tens4(s_n));
    n.su  = units4(s_n);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     q <= '0;
    else if (ld_i)   q <= time_t'(ld_val_i);
    else if (tick_i) q <= n;
  end

  assign time_o    = q;
  assign day_inc_o = tick_i & roll;
endmodule

// File: rtl/rtc_date_ctr.sv
module rtc_date_ctr
  import rtc_cal_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              day_inc_i,
  input  logic              ld_i,
  input  logic [DATE_W-1:0] ld_val_i,
  output logic [DATE_W-1:0] date_o
);
  localparam date_t RST_DATE = '{yt: 4'd0, yu: 4'd0, wd: 3'd1, mt: 1'b0,
                                 mu: 4'd1, dt: 2'd0, du: 4'd1};
  date_t q, n;
  logic [6:0] d, mo, yr, d_n, mo_n, yr_n;

  always_comb begin
    d    = bcd2bin({2'b00, q.dt, q.du});
    mo   = bcd2bin({3'b000, q.mt, q.mu});
    yr   = bcd2bin({q.yt, q.yu});
    d_n  = d + 7'd1;
    mo_n = mo;
    yr_n = yr;
    if (d == month_days(mo, yr)) begin
      d_n = 7'd1;
      if (mo == 7'd12) begin
        mo_n = 7'd1;
        yr_n = (yr == 7'd99) ? 7'd0 : yr + 7'd1;
      end else begin
        mo_n = mo + 7'd1;
      end
    end
    n.wd = (q.wd == 3'd7) ? 3'd1 : q.wd + 3'd1;
    n.yt = tens4(yr_n);
    n.yu = units4(yr_n);
    n.mt = tens4(mo_n) != 4'd0;
    n.mu = units4(mo_n);
    n.dt = 2'(tens4(d_n));
    n.du = units4(d_n);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        q <= RST_DATE;
    else if (ld_i)      q <= date_t'(ld_val_i);
    else if (day_inc_i) q <= n;
  end

  assign date_o = q;
endmodule

// File: rtl/rtc_calendar.sv
module rtc_calendar
  import rtc_cal_pkg::*;
#(
  parameter int APRE_W = 7,
  parameter int SPRE_W = 15
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [APRE_W-1:0] apre_i,
  input  logic [SPRE_W-1:0] spre_i,
  input  logic              fmt12_i,
  input  logic              init_i,
  input  logic              time_ld_i,
  input  logic [TIME_W-1:0] time_i,
  input  logic              date_ld_i,
  input  logic [DATE_W-1:0] date_i,
  output logic [TIME_W-1:0] time_o,
  output logic [DATE_W-1:0] date_o,
  output logic [SPRE_W-1:0] subsec_o,
  output logic              tick_o
);
  logic sec_tick, day_inc, tick_q;

  rtc_prescaler #(.APRE_W(APRE_W), .SPRE_W(SPRE_W)) u_pre (
    .clk_i, .rst_ni, .run_i(!init_i), .apre_i, .spre_i,
    .subsec_o, .sec_tick_o(sec_tick)
  );

  rtc_time_ctr u_time (
    .clk_i, .rst_ni, .fmt12_i, .tick_i(sec_tick),
    .ld_i(init_i & time_ld_i), .ld_val_i(time_i),
    .time_o, .day_inc_o(day_inc)
  );

  rtc_date_ctr u_date (
    .clk_i, .rst_ni, .day_inc_i(day_inc),
    .ld_i(init_i & date_ld_i), .ld_val_i(date_i), .date_o
  );

  // tick_o rises with the updated calendar
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) tick_q <= 1'b0;
    else         tick_q <= sec_tick;
  end
  assign tick_o = tick_q;
endmodule

// File: rtl/rtc_calendar_chk.sv
module rtc_calendar_chk #(
  parameter int SPRE_W = 15,
  parameter int TIME_W = 21,
  parameter int DATE_W = 22
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [SPRE_W-1:0] spre_i,
  input logic              init_i,
  input logic              time_ld_i,
  input logic              date_ld_i,
  input logic [TIME_W-1:0] time_o,
  input logic [DATE_W-1:0] date_o,
  input logic [SPRE_W-1:0] subsec_o,
  input logic              tick_o
);
  // R12
  freeze_time_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (init_i && !time_ld_i) |=> $stable(time_o));
  // R12
  no_tick_init_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    init_i |=> !tick_o);
  // R11
  time_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(time_o) |-> (tick_o || $past(init_i && time_ld_i)));
  // R11
  date_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(date_o) |-> (tick_o || $past(init_i && date_ld_i)));
  // R3
  subsec_reload_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(init_i) && $past(rst_ni)) |-> (subsec_o == $past(spre_i)));
  // R4
  tick_moves_time_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_o |-> !$stable(time_o));
endmodule

bind rtc_calendar rtc_calendar_chk #(.SPRE_W(SPRE_W), .TIME_W(rtc_cal_pkg::TIME_W),
                                     .DATE_W(rtc_cal_pkg::DATE_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .spre_i(spre_i), .init_i(init_i),
  .time_ld_i(time_ld_i), .date_ld_i(date_ld_i), .time_o(time_o),
  .date_o(date_o), .subsec_o(subsec_o), .tick_o(tick_o)
);

// File: tb/rtc_calendar_bench.sv
module rtc_calendar_bench;
  logic clk_i = 1'b0;
  always #5 clk_i = ~clk_i;

  logic        rst_ni, fmt12_i, init_i, time_ld_i, date_ld_i, tick_o;
  logic [6:0]  apre_i;
  logic [14:0] spre_i, subsec_o;
  logic [20:0] time_i, time_o;
  logic [21:0] date_i, date_o;
  int checks = 0, errors = 0;

  rtc_calendar u_rtc_calendar (
    .clk_i, .rst_ni, .apre_i, .spre_i, .fmt12_i, .init_i,
    .time_ld_i, .time_i, .date_ld_i, .date_i,
    .time_o, .date_o, .subsec_o, .tick_o
  );

  function automatic logic [20:0] mk_t(int pm, int h, int m, int s);
    return {1'(pm), 2'(h / 10), 4'(h % 10), 3'(m / 10), 4'(m % 10), 3'(s / 10), 4'(s % 10)};
  endfunction
  function automatic logic [21:0] mk_d(int y, int wd, int mo, int d);
    return {4'(y / 10), 4'(y % 10), 3'(wd), 1'(mo / 10), 4'(mo % 10), 2'(d / 10), 4'(d % 10)};
  endfunction

  typedef struct packed {
    logic        fmt;
    logic [20:0] ti;
    logic [21:0] di;
    logic [20:0] te;
    logic [21:0] de;
  } vec_t;
  localparam int NV = 16;
  localparam vec_t VEC [NV] = '{
    '{1'b0, mk_t(0,0,0,0),    mk_d(0,1,1,1),    mk_t(0,0,0,1),   mk_d(0,1,1,1)},    // R4
    '{1'b0, mk_t(0,12,34,59), mk_d(21,3,3,15),  mk_t(0,12,35,0), mk_d(21,3,3,15)},  // R4
    '{1'b0, mk_t(0,9,59,59),  mk_d(21,3,3,15),  mk_t(0,10,0,0),  mk_d(21,3,3,15)},  // R4
    '{1'b0, mk_t(0,23,59,59), mk_d(21,3,3,15),  mk_t(0,0,0,0),   mk_d(21,4,3,16)},  // R4
    '{1'b0, mk_t(0,23,59,59), mk_d(21,7,4,30),  mk_t(0,0,0,0),   mk_d(21,1,5,1)},   // R7 R9
    '{1'b0, mk_t(0,23,59,59), mk_d(21,2,1,31),  mk_t(0,0,0,0),   mk_d(21,3,2,1)},   // R7
    '{1'b0, mk_t(0,23,59,59), mk_d(23,2,2,28),  mk_t(0,0,0,0),   mk_d(23,3,3,1)},   // R8
    '{1'b0, mk_t(0,23,59,59), mk_d(24,2,2,28),  mk_t(0,0,0,0),   mk_d(24,3,2,29)},  // R8
    '{1'b0, mk_t(0,23,59,59), mk_d(24,3,2,29),  mk_t(0,0,0,0),   mk_d(24,4,3,1)},   // R8
    '{1'b0, mk_t(0,23,59,59), mk_d(99,5,12,31), mk_t(0,0,0,0),   mk_d(0,6,1,1)},    // R10
    '{1'b1, mk_t(0,11,59,59), mk_d(21,3,3,15),  mk_t(1,12,0,0),  mk_d(21,3,3,15)},  // R5 R6
    '{1'b1, mk_t(1,12,59,59), mk_d(21,3,3,15),  mk_t(1,1,0,0),   mk_d(21,3,3,15)},  // R5
    '{1'b1, mk_t(1,11,59,59), mk_d(21,4,9,30),  mk_t(0,12,0,0),  mk_d(21,5,10,1)},  // R6 R7
    '{1'b0, mk_t(0,23,59,59), mk_d(0,1,2,28),   mk_t(0,0,0,0),   mk_d(0,2,2,29)},   // R8
    '{1'b0, mk_t(0,23,59,59), mk_d(21,3,6,30),  mk_t(0,0,0,0),   mk_d(21,4,7,1)},   // R7
    '{1'b0, mk_t(0,19,59,59), mk_d(21,3,3,15),  mk_t(0,20,0,0),  mk_d(21,3,3,15)}   // R4
  };
  string vtag [NV] = '{"R4", "R4", "R4", "R4", "R7 R9", "R7", "R8", "R8", "R8", "R10",
                       "R5 R6", "R5", "R6 R7", "R8", "R7", "R4"};

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic load_cfg(input logic fmt, input logic [20:0] t, input logic [21:0] d);
    @(negedge clk_i);
    init_i = 1'b1; fmt12_i = fmt; time_i = t; date_i = d;
    time_ld_i = 1'b1; date_ld_i = 1'b1;
    @(negedge clk_i);
    time_ld_i = 1'b0; date_ld_i = 1'b0;
    @(negedge clk_i);
  endtask

  task automatic run_to_tick(output int n);
    n = 0;
    do begin
      @(negedge clk_i);
      n++;
    end while (!tick_o && n < 2000);
  endtask

  initial begin
    #3_000_000;
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int n, ticks;
    logic [20:0] t0;
    logic [21:0] d0;
    t0 = mk_t(0, 8, 15, 30);
    d0 = mk_d(21, 3, 3, 15);
    rst_ni = 1'b0; init_i = 1'b1; fmt12_i = 1'b0; time_ld_i = 1'b0; date_ld_i = 1'b0;
    time_i = '0; date_i = '0; apre_i = 7'd1; spre_i = 15'd1;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk("R1 time", 32'(time_o), 32'(mk_t(0, 0, 0, 0)));
    chk("R1 date", 32'(date_o), 32'(mk_d(0, 1, 1, 1)));
    chk("R1 tick", 32'(tick_o), 32'd0);

    // one tick per vector, prescalers divide by 2 and 2
    for (int i = 0; i < NV; i++) begin
      load_cfg(VEC[i].fmt, VEC[i].ti, VEC[i].di);
      init_i = 1'b0;
      run_to_tick(n);
      chk({vtag[i], " time"}, 32'(time_o), 32'(VEC[i].te));
      chk({vtag[i], " date"}, 32'(date_o), 32'(VEC[i].de));
    end

    apre_i = 7'd2; spre_i = 15'd3;
    // R3 sub-second down count
    load_cfg(1'b0, t0, d0);
    chk("R3 subsec in init", 32'(subsec_o), 32'd3);
    init_i = 1'b0;
    repeat (3) @(negedge clk_i);
    chk("R3 subsec step 1", 32'(subsec_o), 32'd2);
    repeat (3) @(negedge clk_i);
    chk("R3 subsec step 2", 32'(subsec_o), 32'd1);
    run_to_tick(n);
    chk("R3 wrap tick", 32'(n), 32'd6);
    chk("R3 subsec wrapped", 32'(subsec_o), 32'd3);

    // R2 tick period
    load_cfg(1'b0, t0, d0);
    init_i = 1'b0;
    run_to_tick(n);
    chk("R2 first period", 32'(n), 32'd12);
    run_to_tick(n);
    chk("R2 second period", 32'(n), 32'd12);
    chk("R2 time", 32'(time_o), 32'(mk_t(0, 8, 15, 32)));

    // R11 loads outside init are ignored
    load_cfg(1'b0, t0, d0);
    init_i = 1'b0;
    time_ld_i = 1'b1; time_i = mk_t(0, 3, 3, 3);
    date_ld_i = 1'b1; date_i = mk_d(44, 6, 6, 6);
    @(negedge clk_i);
    time_ld_i = 1'b0; date_ld_i = 1'b0;
    @(negedge clk_i);
    chk("R11 time kept", 32'(time_o), 32'(t0));
    chk("R11 date kept", 32'(date_o), 32'(d0));

    // R12 freeze mid-count, restart from reload
    load_cfg(1'b0, t0, d0);
    init_i = 1'b0;
    repeat (5) @(negedge clk_i);
    init_i = 1'b1;
    ticks = 0;
    repeat (10) begin
      @(negedge clk_i);
      if (tick_o) ticks++;
    end
    chk("R12 no tick in init", 32'(ticks), 32'd0);
    chk("R12 time frozen", 32'(time_o), 32'(t0));
    chk("R12 subsec reloaded", 32'(subsec_o), 32'd3);
    init_i = 1'b0;
    run_to_tick(n);
    chk("R12 full period after restart", 32'(n), 32'd12);
    chk("R12 time after restart", 32'(time_o), 32'(mk_t(0, 8, 15, 31)));

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule